// File: doc/BRIEF.md
# Parallel Position Word Reader

This block fetches an absolute position value from a register space that is reached over a simple request/response bus. The space holds two parallel banks of 24-bit registers, called X and Y. A single 24-bit configuration word says where the value lives and how to read it. It gives a 16-bit register address, how many bits the value holds, which bank to use, and whether the value is signed.

A one-cycle `start` pulse launches a read. The block issues one or two bus reads, depending on the bit count. It waits for each response, however long that takes. It then joins the returned words and keeps only the requested low bits. The result is zero-extended or sign-extended to 48 bits and presented with a one-cycle `done` strobe. A configuration with an unusable bit count does no bus traffic and finishes at once with an error flag.

Top module: `pos_word_reader`

## Requirements
- R1: The configuration word is decoded as follows:
  - bits 15:0 are the register address;
  - bits 21:16 are the bit count;
  - bit 22 is the bank select, where 0 reads the Y bank and 1 reads the X bank, and `bus_bank` carries this bit unchanged (1 means X);
  - bit 23 is the signedness flag, where 1 means two's-complement.
- R2: With a bit count from 8 to 24, exactly one read is issued, at the configured address. The value is taken from bit 0 of the returned word upward.
- R3: With a bit count from 25 to 48, two reads are issued, in order: first the configured address, then that address plus one, wrapping 0xFFFF to 0x0000. Result bits 24 and up come from bit 0 upward of the second word.
- R4: For an unsigned read, every `pos_out` bit at or above the bit count is 0.
- R5: For a signed read, every `pos_out` bit at or above the bit count equals result bit (count-1).
- R6: A bit count below 8 or above 48 issues no bus read. It produces `done` together with `err`=1 two clock edges after the accepting edge, with `pos_out` equal to 0.
- R7: `bus_req` stays high, with `bus_addr` and `bus_bank` stable, until `bus_rvalid` is seen. Any response latency gives the same result.
- R8: A `start` that arrives while a read sequence is in progress is ignored. The configuration is captured at the accepting edge, so later changes to `cfg` do not affect the sequence under way.
- R9: `done` is a one-cycle pulse. `err` is only high together with `done`. `pos_out` changes only in the cycle that `done` is high and holds its value otherwise.
- R10: After reset, `done`, `err` and `bus_req` are 0 and `pos_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a read sequence |
| cfg | input | 24 | Configuration word: address, bit count, bank, signedness |
| bus_req | output | 1 | Read request, held until the response |
| bus_addr | output | 16 | Register address of the current read |
| bus_bank | output | 1 | Bank of the current read (1 = X, 0 = Y) |
| bus_rdata | input | 24 | Returned register word |
| bus_rvalid | input | 1 | Marks `bus_rdata` valid for the current request |
| pos_out | output | 48 | Assembled and extended position value |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Bad bit count, valid with `done` |

## Verification
The hardest situation to reach is a second `start` that lands while a read is still waiting on the bus. Together with it comes a `cfg` that changes under a running sequence. Both are needed to show that the captured configuration governs the sequence.

The bench's bus responder holds back `bus_rvalid` for a programmable number of cycles. A second start pulse with a different configuration is injected during that wait. The bench then counts the reads issued and the completions seen. The address wrap at 0xFFFF is reached by a two-word request based at that address.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  localparam int ADDR_W   = 16;
  localparam int WORD_W   = 24;
  localparam int CNT_W    = 6;
  localparam int OUT_W    = 2 * WORD_W;
  localparam int CFG_W    = ADDR_W + CNT_W + 2;
  localparam int MIN_BITS = 8;
  localparam int MAX_BITS = OUT_W;

  // Field order follows the configuration word from its top bit down.
  typedef struct packed {
    logic              sgn;
    logic              bank;
    logic [CNT_W-1:0]  nbits;
    logic [ADDR_W-1:0] addr;
  } pwr_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_FIN   = 2'd3
  } pwr_state_e;

  function automatic logic pwr_len_ok(input logic [CNT_W-1:0] n);
    return (int'(n) >= MIN_BITS) && (int'(n) <= MAX_BITS);
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_cfg_decode.sv
module pwr_cfg_decode
  import pwr_pkg::*;
(
  input  pwr_cfg_t          cfg_q,
  output logic              len_ok,
  output logic              two_reads,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [ADDR_W-1:0] addr_hi
);

  always_comb begin
    len_ok    = pwr_len_ok(cfg_q.nbits);
    two_reads = int'(cfg_q.nbits) > WORD_W;
    addr_lo   = cfg_q.addr;
    addr_hi   = cfg_q.addr + ADDR_W'(1);
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              len_ok_in,
  input  logic              two_reads,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic              bank,
  input  logic              rvalid,
  output logic              accept,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bank,
  output logic              lo_en,
  output logic              hi_en,
  output logic              fin
);

  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start)  st_d = len_ok_in ? ST_RD_LO : ST_FIN;
      ST_RD_LO: if (rvalid) st_d = two_reads ? ST_RD_HI : ST_FIN;
      ST_RD_HI: if (rvalid) st_d = ST_FIN;
      ST_FIN:               st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    accept   = (st_q == ST_IDLE) && start;
    bus_req  = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
    bus_addr = (st_q == ST_RD_HI) ? addr_hi : addr_lo;
    bus_bank = bank;
    lo_en    = (st_q == ST_RD_LO) && rvalid;
    hi_en    = (st_q == ST_RD_HI) && rvalid;
    fin      = (st_q == ST_FIN);
  end

endmodule

// File: rtl/pwr_assemble.sv
module pwr_assemble
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic [WORD_W-1:0] rdata,
  input  logic              fin,
  input  logic              len_ok,
  input  logic              sgn,
  input  logic [CNT_W-1:0]  nbits,
  output logic [OUT_W-1:0]  pos_out,
  output logic              done,
  output logic              err
);

  logic [WORD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [OUT_W-1:0]  pos_q, pos_d, joined, ext;
  logic              done_q, done_d, err_q, err_d;
  logic [CNT_W-1:0]  top_idx;
  logic              top_bit;

  // Word capture: cleared on accept so a single read leaves the high word zero.
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      if (lo_en) lo_d = rdata;
      if (hi_en) hi_d = rdata;
    end
  end

  // Length mask and extension.
  always_comb begin
    joined  = {hi_q, lo_q};
    top_idx = nbits - CNT_W'(1);
    top_bit = (int'(top_idx) < OUT_W) ? joined[top_idx] : 1'b0;
    for (int i = 0; i < OUT_W; i++) begin
      ext[i] = (i < int'(nbits)) ? joined[i] : (sgn & top_bit);
    end
  end

  always_comb begin
    pos_d  = pos_q;
    if (fin) pos_d = len_ok ? ext : '0;
    done_d = fin;
    err_d  = fin && !len_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      pos_q  <= pos_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign pos_out = pos_q;
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/pos_word_reader.sv
module pos_word_reader
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bank,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_rvalid,
  output logic [OUT_W-1:0]  pos_out,
  output logic              done,
  output logic              err
);

  logic              rst_n_s;
  pwr_cfg_t          cfg_in, cfg_q, cfg_d;
  logic              accept, len_ok_in, len_ok_q, two_reads;
  logic [ADDR_W-1:0] addr_lo, addr_hi;
  logic              lo_en, hi_en, fin;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Configuration capture, enabled only on an accepted start.
  always_comb begin
    cfg_in    = pwr_cfg_t'(cfg);
    len_ok_in = pwr_len_ok(cfg_in.nbits);
    cfg_d     = accept ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  pwr_cfg_decode u_dec (
    .cfg_q     (cfg_q),
    .len_ok    (len_ok_q),
    .two_reads (two_reads),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi)
  );

  pwr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .len_ok_in (len_ok_in),
    .two_reads (two_reads),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .bank      (cfg_q.bank),
    .rvalid    (bus_rvalid),
    .accept    (accept),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_bank  (bus_bank),
    .lo_en     (lo_en),
    .hi_en     (hi_en),
    .fin       (fin)
  );

  pwr_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (accept),
    .lo_en   (lo_en),
    .hi_en   (hi_en),
    .rdata   (bus_rdata),
    .fin     (fin),
    .len_ok  (len_ok_q),
    .sgn     (cfg_q.sgn),
    .nbits   (cfg_q.nbits),
    .pos_out (pos_out),
    .done    (done),
    .err     (err)
  );

endmodule

// File: rtl/pos_word_reader_chk.sv
module pos_word_reader_chk
  import pwr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_bank,
  input logic              bus_rvalid,
  input logic [OUT_W-1:0]  pos_out,
  input logic              done,
  input logic              err
);

  logic [ADDR_W-1:0] addr_inc;
  assign addr_inc = bus_addr + ADDR_W'(1);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rvalid) |=> (bus_req && $stable(bus_addr) && $stable(bus_bank)));

  // R3
  next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rvalid) |=> (!bus_req || (bus_addr == $past(addr_inc))));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && (pos_out == '0)));

  // R9
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || $stable(pos_out)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

endmodule

bind pos_word_reader pos_word_reader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .bus_req    (bus_req),
  .bus_addr   (bus_addr),
  .bus_bank   (bus_bank),
  .bus_rvalid (bus_rvalid),
  .pos_out    (pos_out),
  .done       (done),
  .err        (err)
);

// File: tb/pos_word_reader_bench.sv
module pos_word_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // {cfg, low word, high word, expected value, latency}
  localparam logic [127:0] VEC [NV] = '{
    {24'h581234, 24'hABCDEF, 24'h000000, 48'h0000_00AB_CDEF, 8'd0},
    {24'h980100, 24'h800001, 24'h000000, 48'hFFFF_FF80_0001, 8'd1},
    {24'h080010, 24'h1234F5, 24'h000000, 48'h0000_0000_00F5, 8'd2},
    {24'h880010, 24'h1234F5, 24'h000000, 48'hFFFF_FFFF_FFF5, 8'd0},
    {24'h880020, 24'hFFFF7F, 24'h000000, 48'h0000_0000_007F, 8'd3},
    {24'h300200, 24'h123456, 24'hFEDCBA, 48'hFEDC_BA12_3456, 8'd0},
    {24'hB00300, 24'h000001, 24'h800000, 48'h8000_0000_0001, 8'd2},
    {24'h200400, 24'hAAAAAA, 24'h1234C3, 48'h0000_C3AA_AAAA, 8'd1},
    {24'hE00400, 24'h000000, 24'h000080, 48'hFFFF_8000_0000, 8'd0},
    {24'h190500, 24'h111111, 24'hFFFFFF, 48'h0000_0111_1111, 8'd4},
    {24'h990500, 24'h111111, 24'hFFFFFF, 48'hFFFF_FF11_1111, 8'd0},
    {24'hD9FFFF, 24'h000005, 24'h000000, 48'h0000_0000_0005, 8'd1}
  };

  logic        clk, rst_n, start, bus_req, bus_bank, bus_rvalid, done, err;
  logic [23:0] cfg, bus_rdata;
  logic [15:0] bus_addr;
  logic [47:0] pos_out;

  int total, bad;
  int nreads, wcnt, cur_lat;
  logic [15:0] exp_addr;
  logic [23:0] cur_lo, cur_hi;
  logic [15:0] log_addr [4];
  logic        log_bank [4];

  pos_word_reader u_pos_word_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_bank(bus_bank),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pos_out(pos_out), .done(done), .err(err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus responder: answers after cur_lat waiting cycles, logs every read.
  initial begin
    bus_rvalid = 1'b0;
    bus_rdata  = '0;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_rvalid) begin
        bus_rvalid = 1'b0;
        wcnt = 0;
      end else if (bus_req) begin
        if (wcnt >= cur_lat) begin
          bus_rvalid = 1'b1;
          bus_rdata  = (bus_addr == exp_addr) ? cur_lo : cur_hi;
          if (nreads < 4) begin
            log_addr[nreads] = bus_addr;
            log_bank[nreads] = bus_bank;
          end
          nreads++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic pulse_start(input logic [23:0] c);
    @(negedge clk);
    cfg   = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int k = 0; k < 300 && !got; k++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run(input logic [23:0] c, input logic [23:0] lo, input logic [23:0] hi,
                     input int lat, input logic [47:0] exp_pos, input bit exp_err);
    bit got;
    int exp_reads;
    logic [15:0] a1;
    logic [47:0] held;
    exp_reads = exp_err ? 0 : ((c[21:16] > 6'd24) ? 2 : 1);
    a1 = c[15:0] + 16'd1;
    exp_addr = c[15:0];
    cur_lo = lo;
    cur_hi = hi;
    cur_lat = lat;
    nreads = 0;
    pulse_start(c);
    wait_done(got);
    chk(got, "R9 done seen", 64'(got), 64'd1);
    chk(err == exp_err, "R6 err flag", 64'(err), 64'(exp_err));
    chk(pos_out == exp_pos, c[23] ? "R5 signed value" : "R4 unsigned value", 64'(pos_out), 64'(exp_pos));
    chk(nreads == exp_reads, (exp_reads == 2) ? "R3 read count" : "R2 read count",
        64'(nreads), 64'(exp_reads));
    if (exp_reads >= 1) begin
      chk(log_addr[0] == c[15:0], "R1 first address", 64'(log_addr[0]), 64'(c[15:0]));
      chk(log_bank[0] == c[22], "R1 bank select", 64'(log_bank[0]), 64'(c[22]));
    end
    if (exp_reads == 2)
      chk(log_addr[1] == a1, "R3 second address", 64'(log_addr[1]), 64'(a1));
    held = pos_out;
    @(negedge clk);
    chk(!done && !err, "R9 done one cycle", 64'({done, err}), 64'd0);
    repeat (2) @(negedge clk);
    chk(pos_out == held, "R9 value held", 64'(pos_out), 64'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    int extra;
    total = 0; bad = 0; nreads = 0; cur_lat = 0;
    exp_addr = '0; cur_lo = '0; cur_hi = '0;
    rst_n = 1'b0; start = 1'b0; cfg = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && !err && !bus_req, "R10 reset flags", 64'({done, err, bus_req}), 64'd0);
    chk(pos_out == '0, "R10 reset value", 64'(pos_out), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [127:0] v;
      v = VEC[i];
      run(v[127:104], v[103:80], v[79:56], int'(v[7:0]), v[55:8], 1'b0);
    end

    // R6 bad bit counts: below minimum, above maximum, zero
    run(24'h070000, 24'hFFFFFF, 24'hFFFFFF, 0, 48'h0, 1'b1);
    run(24'h310000, 24'hFFFFFF, 24'hFFFFFF, 0, 48'h0, 1'b1);
    run(24'h000000, 24'hFFFFFF, 24'hFFFFFF, 0, 48'h0, 1'b1);
    // R2 boundary at minimum count after an error
    run(24'h08ABCD, 24'h0000C8, 24'h0, 2, 48'h0000_0000_00C8, 1'b0);

    // R8 / R7: start and cfg changes during a slow read are ignored
    exp_addr = 16'h1000;
    cur_lo = 24'h00ABCD;
    cur_hi = 24'h777777;
    cur_lat = 8;
    nreads = 0;
    pulse_start(24'h581000);
    @(negedge clk);
    pulse_start(24'hB00777);
    cfg = 24'h070000;
    wait_done(got);
    chk(got, "R8 done after ignored start", 64'(got), 64'd1);
    chk(pos_out == 48'h0000_0000_ABCD, "R7 slow response value", 64'(pos_out), 64'h00ABCD);
    chk(nreads == 1, "R8 read count", 64'(nreads), 64'd1);
    chk(log_addr[0] == 16'h1000, "R8 captured address", 64'(log_addr[0]), 64'h1000);
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || bus_req) extra++;
    end
    chk(extra == 0, "R8 no second sequence", 64'(extra), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule